// File: doc/BRIEF.md
# Infrared Remote Frame Generator

This block drives the baseband line of an infrared remote transmitter. The line is active-low and carries no carrier. When the host asks for a full frame, the block sends a long leader and then a 32-bit payload, followed by a stop mark and a guard gap. The payload holds the address, its bitwise complement, the command and its bitwise complement. Each payload bit is coded by the length of the high space that follows a fixed low mark. When the host asks for a repeat instead, the block sends the short repeat code and then holds a longer guard gap. Between transmissions the line rests high.

Every duration is counted in ticks of a 1 µs enable input and is set by a parameter. The block can therefore run from a fast system clock when a prescaler supplies the tick. The host starts a transmission with a one-cycle request, reads `busy` while the transmission is in progress, and gets a one-cycle `done` at the end of the guard gap. A request is accepted only while `busy` is low. Adding the 38 kHz carrier and driving the LED are left to the logic downstream.

Top module: `ir_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `ir_out` is 1 and `done` is 0. When reset is asserted in the middle of a transmission, it forces `ir_out` to 1 and `busy` to 0 at the next clock edge.
- R2: A full frame begins with `ir_out` low for LEAD_MARK_T ticks, then high for LEAD_SPACE_T ticks. The low level starts in the cycle after the edge that accepts `start_req`.
- R3: Each payload bit is a low mark of BIT_MARK_T ticks followed by a high space. The space lasts ZERO_SPACE_T ticks for a 0 and ONE_SPACE_T ticks for a 1.
- R4: The 32 payload bits go out in this order: `addr_in`, then `~addr_in`, then `cmd_in`, then `~cmd_in`. Each byte goes least-significant bit first. The bytes are captured at the edge that accepts the request.
- R5: After the 32nd bit, the block drives one more low mark of BIT_MARK_T ticks. It then holds `ir_out` high for FRAME_GAP_T ticks before the frame ends.
- R6: A repeat code is LEAD_MARK_T ticks low, then RPT_SPACE_T ticks high, then BIT_MARK_T ticks low, and then RPT_GAP_T ticks high before it ends.
- R7: `rpt_req` is ignored until at least one full frame has completed since reset. While it is ignored, `ir_out` stays 1 and `busy` stays 0.
- R8: Requests and changes of `addr_in` or `cmd_in` that occur while `busy` is high have no effect. The frame already in progress keeps its payload, and no further transmission follows it.
- R9: `busy` is 1 from the cycle after the request is accepted until the guard gap ends. In the cycle where `busy` falls, `done` is 1, and `done` lasts exactly one cycle.
- R10: The timing advances only in cycles where `tick_us` is 1. When the tick arrives every second cycle, a mark of N ticks lasts 2N-1 or 2N clock cycles.
- R11: If `start_req` and `rpt_req` arrive together while the block is idle, the full frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_us | input | 1 | Time-base enable, one pulse per microsecond |
| start_req | input | 1 | Request to send a full frame |
| rpt_req | input | 1 | Request to send a repeat code |
| addr_in | input | 8 | Address byte for the frame |
| cmd_in | input | 8 | Command byte for the frame |
| ir_out | output | 1 | Baseband line, low during marks, idle high |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle pulse when the guard gap ends |

## Verification
A segment counter that is off by one makes a mark or space one tick too long or too short, and this shows at the first segment that uses that counter. A corrupted shift register or bit counter shows up as a wrong or missing bit in the rebuilt 32-bit word. It can also show as a stop mark that arrives early or late, up to one frame later. A wrong sequencer state, such as the repeat flag, the armed flag or the busy flag, shows within one transmission. It appears as a spacing that does not belong to the frame being sent, as a repeat code sent too early, or as a `done` pulse that is missing, appears twice, or does not coincide with `busy` falling.

// File: rtl/ir_frame_tx_pkg.sv
package ir_frame_tx_pkg;

  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 4 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_MARK,
    ST_LEAD_SPACE,
    ST_BIT_MARK,
    ST_BIT_SPACE,
    ST_STOP_MARK,
    ST_GUARD
  } tx_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ir_frame_tx_timer.sv
module ir_frame_tx_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  // segment of N ticks: loaded with N-1, ends on the tick that finds zero
  assign expire = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/ir_frame_tx_payload.sv
module ir_frame_tx_payload
  import ir_frame_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] cmd,
  output logic              cur_bit,
  output logic              last_bit
);

  localparam int IDX_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] word;
  logic [FRAME_W-1:0] sr_q;
  logic [IDX_W-1:0]   idx_q;

  // byte lanes: 0 = addr, 1 = ~addr, 2 = cmd, 3 = ~cmd
  for (genvar b = 0; b < 4; b++) begin : g_lane
    if (b < 2) begin : g_addr
      if (b % 2 == 0) begin : g_true
        assign word[b*BYTE_W +: BYTE_W] = addr;
      end else begin : g_inv
        assign word[b*BYTE_W +: BYTE_W] = ~addr;
      end
    end else begin : g_cmd
      if (b % 2 == 0) begin : g_true
        assign word[b*BYTE_W +: BYTE_W] = cmd;
      end else begin : g_inv
        assign word[b*BYTE_W +: BYTE_W] = ~cmd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sr_q  <= word;
      idx_q <= '0;
    end else if (shift) begin
      sr_q  <= {1'b0, sr_q[FRAME_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = sr_q[0];
  assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));

  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(load && shift)); // R4

endmodule

// File: rtl/ir_frame_tx_ctrl.sv
module ir_frame_tx_ctrl
  import ir_frame_tx_pkg::*;
#(
  parameter int CW           = 17,
  parameter int LEAD_MARK_T  = 9000,
  parameter int LEAD_SPACE_T = 4500,
  parameter int RPT_SPACE_T  = 2250,
  parameter int BIT_MARK_T   = 560,
  parameter int ZERO_SPACE_T = 560,
  parameter int ONE_SPACE_T  = 1690,
  parameter int FRAME_GAP_T  = 40000,
  parameter int RPT_GAP_T    = 102000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          rpt_req,
  input  logic          expire,
  input  logic          cur_bit,
  input  logic          last_bit,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          pl_load,
  output logic          pl_shift,
  output logic          ir_out,
  output logic          busy,
  output logic          done
);

  tx_state_t st_q, st_d;
  logic      rpt_q, armed_q;
  logic      ir_q, busy_q, done_q;
  logic      is_mark_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:       if (start_req || (rpt_req && armed_q)) st_d = ST_LEAD_MARK;
      ST_LEAD_MARK:  if (expire) st_d = ST_LEAD_SPACE;
      ST_LEAD_SPACE: if (expire) st_d = rpt_q ? ST_STOP_MARK : ST_BIT_MARK;
      ST_BIT_MARK:   if (expire) st_d = ST_BIT_SPACE;
      ST_BIT_SPACE:  if (expire) st_d = last_bit ? ST_STOP_MARK : ST_BIT_MARK;
      ST_STOP_MARK:  if (expire) st_d = ST_GUARD;
      ST_GUARD:      if (expire) st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  // every transition opens a new segment
  assign tmr_load = (st_d != st_q);
  assign pl_load  = (st_q == ST_IDLE) && start_req;
  assign pl_shift = (st_q == ST_BIT_SPACE) && expire;

  always_comb begin
    tmr_val = '0;
    unique case (st_d)
      ST_LEAD_MARK:  tmr_val = CW'(LEAD_MARK_T - 1);
      ST_LEAD_SPACE: tmr_val = rpt_q ? CW'(RPT_SPACE_T - 1) : CW'(LEAD_SPACE_T - 1);
      ST_BIT_MARK,
      ST_STOP_MARK:  tmr_val = CW'(BIT_MARK_T - 1);
      ST_BIT_SPACE:  tmr_val = cur_bit ? CW'(ONE_SPACE_T - 1) : CW'(ZERO_SPACE_T - 1);
      ST_GUARD:      tmr_val = rpt_q ? CW'(RPT_GAP_T - 1) : CW'(FRAME_GAP_T - 1);
      default:       tmr_val = '0;
    endcase
  end

  assign is_mark_d = (st_d == ST_LEAD_MARK) || (st_d == ST_BIT_MARK) ||
                     (st_d == ST_STOP_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      rpt_q   <= 1'b0;
      armed_q <= 1'b0;
      ir_q    <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ir_q   <= !is_mark_d;
      busy_q <= (st_d != ST_IDLE);
      done_q <= (st_q == ST_GUARD) && (st_d == ST_IDLE);
      if (st_q == ST_IDLE) begin
        rpt_q <= !start_req;
      end
      if ((st_q == ST_GUARD) && (st_d == ST_IDLE) && !rpt_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign ir_out = ir_q;
  assign busy   = busy_q;
  assign done   = done_q;

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ir_out); // R1
  AST_LEAD_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ir_out); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9
  AST_RPT_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !armed_q) |-> !rpt_q); // R7

endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
  import ir_frame_tx_pkg::*;
#(
  parameter int LEAD_MARK_T  = 9000,
  parameter int LEAD_SPACE_T = 4500,
  parameter int RPT_SPACE_T  = 2250,
  parameter int BIT_MARK_T   = 560,
  parameter int ZERO_SPACE_T = 560,
  parameter int ONE_SPACE_T  = 1690,
  parameter int FRAME_GAP_T  = 40000,
  parameter int RPT_GAP_T    = 102000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_us,
  input  logic        start_req,
  input  logic        rpt_req,
  input  logic [7:0]  addr_in,
  input  logic [7:0]  cmd_in,
  output logic        ir_out,
  output logic        busy,
  output logic        done
);

  localparam int MAX_T = max_of(max_of(max_of(LEAD_MARK_T, LEAD_SPACE_T),
                                       max_of(FRAME_GAP_T, RPT_GAP_T)),
                                max_of(max_of(ONE_SPACE_T, ZERO_SPACE_T),
                                       max_of(BIT_MARK_T, RPT_SPACE_T)));
  localparam int CW = $clog2(MAX_T + 1);

  logic          expire, tmr_load, pl_load, pl_shift, cur_bit, last_bit;
  logic [CW-1:0] tmr_val;

  ir_frame_tx_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_us),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (expire)
  );

  ir_frame_tx_payload i_payload (
    .clk      (clk),
    .rst      (rst),
    .load     (pl_load),
    .shift    (pl_shift),
    .addr     (addr_in),
    .cmd      (cmd_in),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  ir_frame_tx_ctrl #(
    .CW           (CW),
    .LEAD_MARK_T  (LEAD_MARK_T),
    .LEAD_SPACE_T (LEAD_SPACE_T),
    .RPT_SPACE_T  (RPT_SPACE_T),
    .BIT_MARK_T   (BIT_MARK_T),
    .ZERO_SPACE_T (ZERO_SPACE_T),
    .ONE_SPACE_T  (ONE_SPACE_T),
    .FRAME_GAP_T  (FRAME_GAP_T),
    .RPT_GAP_T    (RPT_GAP_T)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .rpt_req   (rpt_req),
    .expire    (expire),
    .cur_bit   (cur_bit),
    .last_bit  (last_bit),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .pl_load   (pl_load),
    .pl_shift  (pl_shift),
    .ir_out    (ir_out),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: tb/test_ir_frame_tx.sv
module test_ir_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int T_LM  = 40;
  localparam int T_LS  = 20;
  localparam int T_RS  = 10;
  localparam int T_BM  = 4;
  localparam int T_B0  = 4;
  localparam int T_B1  = 12;
  localparam int T_FG  = 100;
  localparam int T_RG  = 150;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_us = 1'b1;
  logic       slow = 1'b0;
  logic       start_req = 1'b0;
  logic       rpt_req = 1'b0;
  logic [7:0] addr_in = 8'h00;
  logic [7:0] cmd_in = 8'h00;
  logic       ir_out, busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  ir_frame_tx #(
    .LEAD_MARK_T(T_LM), .LEAD_SPACE_T(T_LS), .RPT_SPACE_T(T_RS),
    .BIT_MARK_T(T_BM), .ZERO_SPACE_T(T_B0), .ONE_SPACE_T(T_B1),
    .FRAME_GAP_T(T_FG), .RPT_GAP_T(T_RG)
  ) i_ir_frame_tx (
    .clk(clk), .rst(rst), .tick_us(tick_us), .start_req(start_req),
    .rpt_req(rpt_req), .addr_in(addr_in), .cmd_in(cmd_in),
    .ir_out(ir_out), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tick_us = slow ? ~tick_us : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (ir_out === lvl && done !== 1'b1 && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic request(input bit s, input bit r, input logic [7:0] a, input logic [7:0] c);
    @(negedge clk);
    start_req = s; rpt_req = r; addr_in = a; cmd_in = c;
    @(negedge clk);
    start_req = 0; rpt_req = 0;
  endtask

  task automatic rx_frame(input logic [7:0] a, input logic [7:0] c);
    int n;
    logic [31:0] w, exp_w;
    exp_w = {~c, c, ~a, a};
    w = '0;
    check(busy === 1'b1, "R9 busy after accept", int'(busy), 1);
    run_len(1'b0, n); check(n == T_LM, "R2 leader mark", n, T_LM);
    run_len(1'b1, n); check(n == T_LS, "R2 leader space", n, T_LS);
    for (int i = 0; i < 32; i++) begin
      run_len(1'b0, n); check(n == T_BM, "R3 bit mark", n, T_BM);
      run_len(1'b1, n);
      check(n == T_B0 || n == T_B1, "R3 bit space", n, T_B0);
      w[i] = (n == T_B1);
    end
    check(w == exp_w, "R4 payload word", int'(w), int'(exp_w));
    run_len(1'b0, n); check(n == T_BM, "R5 stop mark", n, T_BM);
    run_len(1'b1, n); check(n == T_FG, "R5 frame guard", n, T_FG);
    check(done === 1'b1 && busy === 1'b0, "R9 done with busy low", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic rx_repeat();
    int n;
    run_len(1'b0, n); check(n == T_LM, "R6 repeat lead mark", n, T_LM);
    run_len(1'b1, n); check(n == T_RS, "R6 repeat space", n, T_RS);
    run_len(1'b0, n); check(n == T_BM, "R6 repeat end mark", n, T_BM);
    run_len(1'b1, n); check(n == T_RG, "R6 repeat guard", n, T_RG);
    check(done === 1'b1 && busy === 1'b0, "R9 repeat done", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic stay_idle(input int cycles, input string req);
    int errs = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (ir_out !== 1'b1 || busy !== 1'b0 || done !== 1'b0) errs++;
    end
    check(errs == 0, req, errs, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ir_out === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset state",
          int'({ir_out, busy, done}), 4);
  endtask

  task automatic t_rpt_unarmed();
    request(0, 1, 8'h00, 8'h00);
    stay_idle(60, "R7 repeat before any frame ignored");
  endtask

  task automatic t_frame(input logic [7:0] a, input logic [7:0] c);
    request(1, 0, a, c);
    rx_frame(a, c);
    stay_idle(5, "R1 line high after frame");
  endtask

  task automatic t_repeat();
    request(0, 1, 8'h00, 8'h00);
    check(busy === 1'b1, "R6 repeat accepted", int'(busy), 1);
    rx_repeat();
  endtask

  task automatic t_busy_ignore();
    request(1, 0, 8'h5A, 8'hC3);
    fork
      rx_frame(8'h5A, 8'hC3);
      begin
        repeat (40) @(negedge clk);
        start_req = 1; addr_in = 8'hFF; cmd_in = 8'h00;
        @(negedge clk);
        start_req = 0; rpt_req = 1;
        @(negedge clk);
        rpt_req = 0;
      end
    join
    stay_idle(40, "R8 no transmission after busy-time requests");
  endtask

  task automatic t_both();
    request(1, 1, 8'h00, 8'hFF);
    rx_frame(8'h00, 8'hFF); // R11 full frame wins
  endtask

  task automatic t_slow_tick();
    int n;
    slow = 1;
    request(0, 1, 8'h00, 8'h00);
    run_len(1'b0, n);
    check(n == 2*T_LM || n == 2*T_LM - 1, "R10 mark stretched by tick", n, 2*T_LM);
    while (done !== 1'b1) @(negedge clk);
    slow = 0;
    @(negedge clk);
  endtask

  task automatic t_mid_reset();
    request(1, 0, 8'hA5, 8'h3C);
    repeat (30) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check(ir_out === 1'b1 && busy === 1'b0, "R1 reset mid-frame", int'({ir_out, busy}), 2);
    rst = 0;
    t_rpt_unarmed();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_rpt_unarmed();
    t_frame(8'h80, 8'h04);
    t_repeat();
    t_repeat();
    t_busy_ignore();
    t_both();
    t_slow_tick();
    t_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule